// File: doc/BRIEF.md
# Clear-only initialized four-stage ring counter

This block is a circulating one-hot ring of four storage stages. A single 1 moves one place toward the least significant output on each rising clock edge where shifting is enabled. After the last position the 1 returns to the most significant output. An active-low initialize input puts the outputs in their starting pattern at once, without waiting for a clock edge. The starting pattern is `ring_q = 4'b1000`.

All four storage elements have only an asynchronous clear and no preset. The leading stage must still come up at 1. To do this, that stage keeps its bit in inverted form: its data input passes through an inverter before storage, and its stored value passes through a second inverter before it reaches the output and the next stage. After a clear every element holds 0, yet the outputs read 1000. From outside, the inverted stage cannot be told apart from an ordinary ring.

The ring has four states: POS3 (1000), POS2 (0100), POS1 (0010) and POS0 (0001). It has these transitions:
- Each enabled edge moves POS3 to POS2, POS2 to POS1, POS1 to POS0, and POS0 back to POS3.
- A disabled edge leaves the state unchanged.
- Initialize forces POS3 from any state.

Top module: `clr_ring4`

## Requirements
- R1: While `init_n` is low, `ring_q` equals 4'b1000 (bit 3 high). The value appears without any clock edge once `init_n` falls.
- R2: While `init_n` is low, rising clock edges leave `ring_q` at 4'b1000, even when `shift_en` is high.
- R3: On a rising edge with `init_n` high and `shift_en` high, each output bit takes the value of the next higher bit: 1000 becomes 0100, then 0010, then 0001.
- R4: On an enabled edge, bit 0 wraps into bit 3, so 0001 becomes 1000.
- R5: On a rising edge with `shift_en` low, `ring_q` keeps its value.
- R6: After any initialize, exactly one bit of `ring_q` is 1 on every cycle, for any pattern of `shift_en`.
- R7: Initialization uses only the asynchronous clear of each storage element. Right after initialize, every storage element holds 0, including the inverted leading stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| init_n | input | 1 | Active-low asynchronous initialize to 1000 |
| shift_en | input | 1 | High to advance the ring on a clock edge |
| ring_q | output | 4 | Ring outputs, bit 3 is the leading position |

## Verification
The ring first runs with enable held high for more than one full turn. This separates a correct downward rotation and wrap from a wrong direction or a lost bit. Bursts of disabled cycles and an irregular enable pattern then show whether holding differs from advancing at every position. Initialize is applied in the middle of a cycle from a non-start position, and again while enabled edges keep arriving. The first case proves the start pattern is asynchronous. The second proves it wins over the clock. A wrong polarity on either inverter of the leading stage shows up as a second or a missing 1.

// File: rtl/clr_ring_pkg.sv
package clr_ring_pkg;

    // Storage variant of one ring stage
    typedef enum logic [0:0] {
        STAGE_PLAIN   = 1'b0,
        STAGE_FLIPPED = 1'b1
    } stage_kind_e;

endpackage

// File: rtl/clr_ring_stage.sv
module clr_ring_stage
    import clr_ring_pkg::*;
#(
    parameter stage_kind_e KIND = STAGE_PLAIN
) (
    input  logic clk,
    input  logic clr_n,
    input  logic adv,
    input  logic d,
    output logic q
);

    logic held;   // cleared-only storage bit

    generate
        if (KIND == STAGE_FLIPPED) begin : g_flipped
            // inverted on the way in and on the way out
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    held <= 1'b0;
                else if (adv)
                    held <= ~d;
            end
            assign q = ~held;
        end else begin : g_plain
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    held <= 1'b0;
                else if (adv)
                    held <= d;
            end
            assign q = held;
        end
    endgenerate

endmodule

// File: rtl/clr_ring4.sv
module clr_ring4
    import clr_ring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             init_n,
    input  logic             shift_en,
    output logic [WIDTH-1:0] ring_q
);

    localparam int LEAD = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            // each stage takes the stage above it; the lowest wraps to the top
            if (i == LEAD) begin : g_lead
                assign stage_d[i] = stage_q[0];
                clr_ring_stage #(.KIND(STAGE_FLIPPED)) u_stage (
                    .clk   (clk),
                    .clr_n (init_n),
                    .adv   (shift_en),
                    .d     (stage_d[i]),
                    .q     (stage_q[i])
                );
            end else begin : g_follow
                assign stage_d[i] = stage_q[i+1];
                clr_ring_stage #(.KIND(STAGE_PLAIN)) u_stage (
                    .clk   (clk),
                    .clr_n (init_n),
                    .adv   (shift_en),
                    .d     (stage_d[i]),
                    .q     (stage_q[i])
                );
            end
        end
    endgenerate

    assign ring_q = stage_q;

endmodule

// File: rtl/clr_ring4_chk.sv
module clr_ring4_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             init_n,
    input logic             shift_en,
    input logic [WIDTH-1:0] ring_q,
    input logic             lead_held
);

    localparam logic [WIDTH-1:0] START = {1'b1, {(WIDTH-1){1'b0}}};

    // R1 / R2: initialize holds the start pattern
    p_init_value_r1: assert property (@(negedge clk)
        !init_n |-> ring_q == START);

    // R7: the inverted lead stage stores 0 during initialize
    p_lead_cleared_r7: assert property (@(negedge clk)
        !init_n |-> lead_held == 1'b0);

    // R3 / R4: enabled edge rotates toward bit 0 with wrap
    p_shift_r3: assert property (@(posedge clk) disable iff (!init_n)
        shift_en |=> ring_q == {$past(ring_q[0]), $past(ring_q[WIDTH-1:1])});

    // R5: disabled edge holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!init_n)
        !shift_en |=> $stable(ring_q));

    // R6: always exactly one bit set
    p_onehot_r6: assert property (@(negedge clk) disable iff (!init_n)
        $countones(ring_q) == 1);

endmodule

bind clr_ring4 clr_ring4_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .init_n    (init_n),
    .shift_en  (shift_en),
    .ring_q    (ring_q),
    .lead_held (g_stage[WIDTH-1].g_lead.u_stage.held)
);

// File: tb/clr_ring4_tb.sv
module clr_ring4_tb;

    logic       clk = 1'b0;
    logic       init_n = 1'b0;
    logic       shift_en = 1'b0;
    logic [3:0] ring_q;

    int n_checks = 0;
    int n_errors = 0;
    int pos;        // reference model: index of the set bit
    bit done = 0;

    clr_ring4 u_dut (
        .clk      (clk),
        .init_n   (init_n),
        .shift_en (shift_en),
        .ring_q   (ring_q)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] model_val();
        return 4'(1 << pos);
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (ring_q !== model_val()) begin
            n_errors++;
            $display("FAIL %s: ring_q=%b expected=%b", req, ring_q, model_val());
        end
    endtask

    // called at a falling edge; applies en for one rising edge, checks at next fall
    task automatic tick(input logic en, input string req);
        shift_en = en;
        @(posedge clk);
        if (!init_n)       pos = 3;
        else if (en)       pos = (pos == 0) ? 3 : pos - 1;
        @(negedge clk);
        check(req);
        if ($countones(ring_q) != 1) begin
            n_errors++;
            $display("FAIL R6: ring_q=%b expected one bit set", ring_q);
        end
        n_checks++;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        pos = 3;
        #1;
        check("R1 reset state");
        @(negedge clk);
        check("R1 reset state after edge");
        check("R7 clear-only start reads 1000");
        init_n = 1'b1;

        // full turn plus one: shift and wrap
        tick(1'b1, "R3 1000->0100");
        tick(1'b1, "R3 0100->0010");
        tick(1'b1, "R3 0010->0001");
        tick(1'b1, "R4 wrap 0001->1000");
        tick(1'b1, "R3 second turn");

        // hold bursts
        tick(1'b0, "R5 hold");
        tick(1'b0, "R5 hold");
        tick(1'b1, "R3 after hold");
        tick(1'b0, "R5 hold at 0010");

        // asynchronous initialize mid-cycle
        #2 init_n = 1'b0;
        #1 pos = 3;
        check("R1 async without edge");
        @(negedge clk);
        tick(1'b1, "R2 enabled edge during init");
        tick(1'b1, "R2 enabled edge during init");
        init_n = 1'b1;

        // irregular enable pattern
        for (int k = 0; k < 24; k++) begin
            tick(logic'((16'hB5A3 >> (k % 16)) & 1), "R6 pattern");
        end
        for (int k = 0; k < 4; k++) tick(1'b1, "R4 wrap sweep");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule